// File: doc/BRIEF.md
# SDRAM Command Decoder and Two-Bank State Tracker

This block watches the control side of a single-data-rate SDRAM port from the device's point of view. On every rising clock edge it samples the strobes, the bank select line, the address bus, the clock-enable input and the two byte mask inputs. From these it produces a registered command code and latches the row, column and mode addresses. It also keeps an idle or active flag for each bank and raises a flag when a command does not fit the current bank state.

Clock-enable low on one edge suspends the following edges. During a suspended edge no command is taken, and the bank state, the latched addresses and the mask pipeline hold their values. If both banks are idle when the suspension starts, a power-down flag is raised. The byte mask inputs give two outputs: a write mask that applies to data sampled on the same edge, and a read output-enable that takes effect a fixed number of edges later. A read or write with its auto-precharge bit set returns the bank to idle after a parameterized number of enabled edges.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: After a synchronous reset, all of the following hold: cmd_o is 0, both banks are idle, err_o is 0, wr_mask_o is 0, rd_oe_o is 2'b11, and susp_o and pd_o are 0.
- R2: On an edge where cs_n is sampled high, no command is taken. cmd_o reports 0 (no-op) and the bank state does not change.
- R3: With cs_n low, {ras_n,cas_n,we_n} is decoded as follows, and cmd_o reports the code after the edge: 011 activate (code 1), 101 read (2), 100 write (3), 010 precharge (4), 001 refresh (5), 000 mode set (6). The patterns 111 and 110 are no-ops (0).
- R4: Activate makes the bank named by bank_sel active. addr[10:0] is latched into row_o and bank_sel into cmd_bank_o.
- R5: Read and write latch addr[7:0] into col_o and addr[10] into ap_o. They do not change the bank state.
- R6: Precharge with addr[10] low idles only the bank named by bank_sel. With addr[10] high it idles both banks.
- R7: A read or write with addr[10] high, issued to an active bank at edge k, leaves that bank active through edge k+AP_DELAY-1. The bank is idle after edge k+AP_DELAY.
- R8: err_o is a one-edge flag vector. Bit 0 is set for a read or write to an idle bank. Bit 1 is set for an activate to an active bank. Bit 2 is set for a mode set while any bank is active. At most one bit is set on any edge.
- R9: If a bank's auto-precharge completes on the same edge that a command targets that bank, the command sees the bank as idle. An activate then succeeds with no error, and a read or write sets err_o bit 0.
- R10: When cke is sampled low at edge k, edge k itself is processed normally. Every later edge is suspended until the edge after cke is sampled high again. On a suspended edge, bank state, row_o, col_o and the mask outputs hold, cmd_o reports 0, and susp_o is 1 after any edge where cke was sampled low.
- R11: pd_o is set by a processed edge with cke low when both banks are idle after that edge. It holds while cke stays low and clears on the edge where cke is sampled high. pd_o is never 1 while a bank is active.
- R12: dqm bit 1 covers data bits 15..8 and bit 0 covers bits 7..0. wr_mask_o shows dqm as sampled on the last processed edge. rd_oe_o is the inverse of dqm sampled RD_LAT processed edges earlier.
- R13: A mode set with both banks idle latches addr[10:0] into mode_o. A mode set that raises err_o bit 2 leaves mode_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Target bank |
| addr | input | 11 | Row, column, flag and opcode bits |
| dqm | input | 2 | Byte masks, bit 1 upper byte |
| cmd_o | output | 3 | Decoded command code |
| cmd_bank_o | output | 1 | Bank of last bank command |
| row_o | output | 11 | Last activate row |
| col_o | output | 8 | Last access column |
| ap_o | output | 1 | Auto-precharge flag of last access |
| mode_o | output | 11 | Last accepted mode opcode |
| bank_act_o | output | 2 | Active flag per bank |
| err_o | output | 3 | Protocol error flags |
| wr_mask_o | output | 2 | Write byte mask |
| rd_oe_o | output | 2 | Read byte output enable |
| susp_o | output | 1 | Clock suspended |
| pd_o | output | 1 | Power-down state |

## Verification
Auto-precharge completion and a new command to the same bank can fall on the same edge, and the two would disagree about the bank state. The bench schedules a write with auto-precharge and counts out AP_DELAY-1 no-op edges. On the very next edge it issues an activate and, in a second run, a read. The first must leave the bank active with no error; the second must leave it idle with err_o bit 0 set. A second overlap, between a command and a cke-low edge, is judged by checking that the command on that edge still takes effect while the command on the next edge is dropped.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011: cmd = CMD_ACT;
        3'b010: cmd = CMD_PRE;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = CMD_WR;
        3'b001: cmd = CMD_REF;
        3'b000: cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int AP_DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic act_hit,
  input  logic pre_hit,
  input  logic acc_hit,
  input  logic acc_ap,
  output logic live,
  output logic active_o
);
  localparam int CW = $clog2(AP_DELAY + 1);

  logic [CW-1:0] cnt;
  logic          ap_done;

  assign ap_done = (cnt == CW'(1));
  // bank as seen by the command on this edge: completion wins over the command
  assign live    = active_o && !ap_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cnt      <= '0;
    end else if (en) begin
      if (pre_hit) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else if (act_hit && !live) begin
        active_o <= 1'b1;
        cnt      <= '0;
      end else if (acc_hit && live && acc_ap) begin
        cnt <= CW'(AP_DELAY);
      end else if (ap_done) begin
        active_o <= 1'b0;
        cnt      <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/sdr_mask_pipe.sv
module sdr_mask_pipe #(
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] wr_mask,
  output logic [LANES-1:0] rd_oe
);
  logic [LANES-1:0] stg [RD_LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mask <= '0;
      for (int i = 0; i <= RD_LAT; i++) stg[i] <= '0;
    end else if (en) begin
      wr_mask <= dqm;
      stg[0]  <= dqm;
      for (int i = 1; i <= RD_LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign rd_oe = ~stg[RD_LAT];
endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int LANES     = 2,
  parameter int AP_DELAY  = 4,
  parameter int RD_LAT    = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ROW_W-1:0]  addr,
  input  logic [LANES-1:0]  dqm,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic [ROW_W-1:0]  mode_o,
  output logic [NUM_BANKS-1:0] bank_act_o,
  output logic [2:0]        err_o,
  output logic [LANES-1:0]  wr_mask_o,
  output logic [LANES-1:0]  rd_oe_o,
  output logic              susp_o,
  output logic              pd_o
);
  localparam int FLAG_BIT = ROW_W - 1;

  cmd_e                 dec_cmd;
  logic                 run_en;
  logic [NUM_BANKS-1:0] act_hit, pre_hit, acc_hit, live_vec, nxt_act;
  logic                 is_acc, any_live, idle_next;
  logic [2:0]           err_now;

  sdr_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(dec_cmd)
  );

  assign is_acc = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic tgt;
    assign tgt        = (bank_sel == BANK_W'(b));
    assign act_hit[b] = (dec_cmd == CMD_ACT) && tgt;
    assign acc_hit[b] = is_acc && tgt;
    assign pre_hit[b] = (dec_cmd == CMD_PRE) && (addr[FLAG_BIT] || tgt);
    assign nxt_act[b] = pre_hit[b] ? 1'b0 : (act_hit[b] ? 1'b1 : live_vec[b]);

    sdr_bank_slot #(.AP_DELAY(AP_DELAY)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .en      (run_en),
      .act_hit (act_hit[b]),
      .pre_hit (pre_hit[b]),
      .acc_hit (acc_hit[b]),
      .acc_ap  (addr[FLAG_BIT]),
      .live    (live_vec[b]),
      .active_o(bank_act_o[b])
    );
  end

  assign any_live  = |live_vec;
  assign idle_next = ~|nxt_act;
  assign err_now   = {(dec_cmd == CMD_MRS) && any_live,
                      |(act_hit & live_vec),
                      |(acc_hit & ~live_vec)};

  sdr_mask_pipe #(.LANES(LANES), .RD_LAT(RD_LAT)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .en     (run_en),
    .dqm    (dqm),
    .wr_mask(wr_mask_o),
    .rd_oe  (rd_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en     <= 1'b1;
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      row_o      <= '0;
      col_o      <= '0;
      ap_o       <= 1'b0;
      mode_o     <= '0;
      err_o      <= '0;
      susp_o     <= 1'b0;
      pd_o       <= 1'b0;
    end else begin
      run_en <= cke;
      susp_o <= !cke;
      pd_o   <= !cke && (run_en ? idle_next : pd_o);
      if (run_en) begin
        cmd_o <= dec_cmd;
        err_o <= err_now;
        if (dec_cmd == CMD_ACT || dec_cmd == CMD_PRE || is_acc)
          cmd_bank_o <= bank_sel;
        if (dec_cmd == CMD_ACT)
          row_o <= addr;
        if (is_acc) begin
          col_o <= addr[COL_W-1:0];
          ap_o  <= addr[FLAG_BIT];
        end
        if (dec_cmd == CMD_MRS && !any_live)
          mode_o <= addr;
      end else begin
        cmd_o <= CMD_NOP;
        err_o <= '0;
      end
    end
  end
endmodule

// File: rtl/sdr_trk_checker.sv
module sdr_trk_checker #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int BANK_W    = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run_en,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BANK_W-1:0]    bank_sel,
  input logic [ROW_W-1:0]     addr,
  input logic [2:0]           cmd_o,
  input logic [ROW_W-1:0]     row_o,
  input logic [NUM_BANKS-1:0] bank_act_o,
  input logic [2:0]           err_o,
  input logic                 pd_o
);
  AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cmd_o == 3'd0)); // R2

  AST_ACT_SETS_BANK: assert property (@(posedge clk) disable iff (rst)
    (run_en && !cs_n && {ras_n, cas_n, we_n} == 3'b011 && bank_sel == '0) |=> bank_act_o[0]); // R4

  AST_PRE_ALL_IDLES: assert property (@(posedge clk) disable iff (rst)
    (run_en && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && addr[ROW_W-1]) |=> (bank_act_o == '0)); // R6

  AST_ERR_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_o)); // R8

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(bank_act_o) && $stable(row_o))); // R10

  AST_PD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    pd_o |-> (bank_act_o == '0)); // R11
endmodule

bind sdr_cmd_tracker sdr_trk_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
  .cmd_o(cmd_o), .row_o(row_o), .bank_act_o(bank_act_o), .err_o(err_o),
  .pd_o(pd_o)
);

// File: tb/sdr_cmd_tracker_tb_top.sv
module sdr_cmd_tracker_tb_top;
  localparam int APD = 4;

  logic        clk = 1'b0;
  logic        rst, cke, cs_n, ras_n, cas_n, we_n, bank_sel;
  logic [10:0] addr;
  logic [1:0]  dqm;
  logic [2:0]  cmd_o, err_o;
  logic        cmd_bank_o, ap_o, susp_o, pd_o;
  logic [10:0] row_o, mode_o;
  logic [7:0]  col_o;
  logic [1:0]  bank_act_o, wr_mask_o, rd_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  sdr_cmd_tracker #(.AP_DELAY(APD)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_sel(bank_sel), .addr(addr), .dqm(dqm),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .row_o(row_o), .col_o(col_o),
    .ap_o(ap_o), .mode_o(mode_o), .bank_act_o(bank_act_o), .err_o(err_o),
    .wr_mask_o(wr_mask_o), .rd_oe_o(rd_oe_o), .susp_o(susp_o), .pd_o(pd_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // code: 0 nop,1 act,2 rd,3 wr,4 pre,5 ref,6 mrs,7 deselect
  task automatic step(input int code, input logic bk, input logic [10:0] a,
                      input logic ck = 1'b1, input logic [1:0] m = 2'b00);
    @(negedge clk);
    cke = ck; bank_sel = bk; addr = a; dqm = m; cs_n = 1'b0;
    case (code)
      1: {ras_n, cas_n, we_n} = 3'b011;
      2: {ras_n, cas_n, we_n} = 3'b101;
      3: {ras_n, cas_n, we_n} = 3'b100;
      4: {ras_n, cas_n, we_n} = 3'b010;
      5: {ras_n, cas_n, we_n} = 3'b001;
      6: {ras_n, cas_n, we_n} = 3'b000;
      7: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    @(posedge clk); #1ns;
  endtask

  task automatic t_reset();
    chk("R1 cmd", cmd_o, 0);       chk("R1 banks", bank_act_o, 0);
    chk("R1 err", err_o, 0);       chk("R1 wmask", wr_mask_o, 0);
    chk("R1 rdoe", rd_oe_o, 2'b11); chk("R1 susp", susp_o, 0);
    chk("R1 pd", pd_o, 0);
  endtask

  task automatic t_deselect();
    step(7, 1'b0, 11'h123);
    chk("R2 cmd", cmd_o, 0); chk("R2 banks", bank_act_o, 0);
  endtask

  task automatic t_act_access();
    step(1, 1'b1, 11'h5A3);
    chk("R3 act code", cmd_o, 1); chk("R4 bank", bank_act_o, 2'b10);
    chk("R4 row", row_o, 11'h5A3); chk("R4 cbank", cmd_bank_o, 1);
    step(3, 1'b1, 11'h33C);
    chk("R3 wr code", cmd_o, 3); chk("R5 col", col_o, 8'h3C);
    chk("R5 ap", ap_o, 0); chk("R5 banks", bank_act_o, 2'b10);
    step(2, 1'b1, 11'h07F);
    chk("R3 rd code", cmd_o, 2); chk("R5 col rd", col_o, 8'h7F);
  endtask

  task automatic t_errors();
    step(2, 1'b0, 11'h010);
    chk("R8 idle acc", err_o, 3'b001);
    step(1, 1'b1, 11'h222);
    chk("R8 dbl act", err_o, 3'b010); chk("R8 banks", bank_act_o, 2'b10);
    step(6, 1'b0, 11'h155);
    chk("R8 mrs busy", err_o, 3'b100); chk("R13 mode kept", mode_o, 0);
    step(0, 1'b0, 11'h0);
    chk("R8 clear", err_o, 0);
  endtask

  task automatic t_precharge();
    step(1, 1'b0, 11'h001);
    chk("R4 both", bank_act_o, 2'b11);
    step(4, 1'b0, 11'h000);
    chk("R6 single", bank_act_o, 2'b10); chk("R3 pre code", cmd_o, 4);
    step(4, 1'b0, 11'h400);
    chk("R6 all", bank_act_o, 2'b00);
  endtask

  task automatic t_mrs_ref();
    step(6, 1'b0, 11'h237);
    chk("R3 mrs code", cmd_o, 6); chk("R13 mode", mode_o, 11'h237);
    chk("R13 err", err_o, 0);
    step(5, 1'b0, 11'h0);
    chk("R3 ref code", cmd_o, 5);
    step(0, 1'b0, 11'h0);
    chk("R3 nop code", cmd_o, 0);
  endtask

  task automatic t_autopre();
    step(1, 1'b0, 11'h0AA);
    step(2, 1'b0, 11'h412);
    chk("R5 ap set", ap_o, 1); chk("R5 col ap", col_o, 8'h12);
    for (int i = 1; i < APD; i++) step(0, 1'b0, 11'h0);
    chk("R7 still active", bank_act_o, 2'b01);
    step(0, 1'b0, 11'h0);
    chk("R7 idle", bank_act_o, 2'b00);
  endtask

  task automatic t_collide();
    step(1, 1'b0, 11'h0AA);
    step(3, 1'b0, 11'h400);
    for (int i = 1; i < APD; i++) step(0, 1'b0, 11'h0);
    step(1, 1'b0, 11'h3CC);
    chk("R9 act err", err_o, 0); chk("R9 act bank", bank_act_o, 2'b01);
    chk("R9 row", row_o, 11'h3CC);
    step(3, 1'b0, 11'h400);
    for (int i = 1; i < APD; i++) step(0, 1'b0, 11'h0);
    step(2, 1'b0, 11'h005);
    chk("R9 rd err", err_o, 3'b001); chk("R9 rd bank", bank_act_o, 2'b00);
  endtask

  task automatic t_suspend();
    step(1, 1'b0, 11'h111, 1'b0);
    chk("R10 first taken", bank_act_o, 2'b01); chk("R10 row", row_o, 11'h111);
    chk("R10 susp", susp_o, 1); chk("R11 no pd", pd_o, 0);
    step(4, 1'b0, 11'h400, 1'b0, 2'b11);
    chk("R10 frozen bank", bank_act_o, 2'b01); chk("R10 cmd nop", cmd_o, 0);
    chk("R10 wmask held", wr_mask_o, 0);
    step(4, 1'b0, 11'h400, 1'b1);
    chk("R10 wake edge frozen", bank_act_o, 2'b01); chk("R10 susp off", susp_o, 0);
    step(4, 1'b0, 11'h400);
    chk("R10 resumed", bank_act_o, 2'b00);
  endtask

  task automatic t_powerdown();
    step(0, 1'b0, 11'h0, 1'b0);
    chk("R11 pd on", pd_o, 1); chk("R11 susp", susp_o, 1);
    step(1, 1'b1, 11'h0, 1'b0);
    chk("R11 pd held", pd_o, 1); chk("R11 ignored act", bank_act_o, 0);
    step(0, 1'b0, 11'h0, 1'b1);
    chk("R11 pd off", pd_o, 0);
    step(0, 1'b0, 11'h0);
  endtask

  task automatic t_masks();
    step(0, 1'b0, 11'h0, 1'b1, 2'b10);
    chk("R12 wmask", wr_mask_o, 2'b10); chk("R12 rdoe k", rd_oe_o, 2'b11);
    step(0, 1'b0, 11'h0, 1'b1, 2'b01);
    chk("R12 wmask2", wr_mask_o, 2'b01); chk("R12 rdoe k1", rd_oe_o, 2'b11);
    step(0, 1'b0, 11'h0);
    chk("R12 rdoe upper off", rd_oe_o, 2'b01);
    step(0, 1'b0, 11'h0);
    chk("R12 rdoe lower off", rd_oe_o, 2'b10);
    step(0, 1'b0, 11'h0);
    chk("R12 rdoe back", rd_oe_o, 2'b11); chk("R12 wmask clear", wr_mask_o, 0);
  endtask

  initial begin
    rst = 1'b1; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    bank_sel = 1'b0; addr = '0; dqm = '0;
    repeat (3) @(posedge clk);
    #1ns;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_deselect();
    t_act_access();
    t_errors();
    t_precharge();
    t_mrs_ref();
    t_autopre();
    t_collide();
    t_suspend();
    t_powerdown();
    t_masks();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #50us;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule